// File: doc/BRIEF.md
# Thermometer Bit Packer

This block takes an N-bit vector and returns an N-bit vector of the same width in which every set bit of the input has been moved down to the least-significant end. The result is a thermometer code: the low `k` bits are one and the rest are zero, where `k` is the number of ones in the input. The positions of the input ones do not matter, only how many there are.

The ones are counted by a balanced binary adder tree. At each level the list of terms is split at its midpoint, and each single input bit is zero-extended to the count width. The count is `clog2(N+1)` bits wide, so a full vector can be represented. Each output bit `i` then compares the count with the constant `i`. An optional output register adds one cycle of latency and has a synchronous active-high reset. The block has no handshake and no back-pressure: it accepts a new vector every cycle. Any per-bit payload reordering belongs to the surrounding logic.

Top module: `therm_packer`

## Requirements
- R1: Output bit i is 1 exactly when the number of ones in the input is strictly greater than i, for every i from 0 to N-1.
- R2: The internal count is clog2(N+1) bits wide. An all-ones input therefore yields an all-ones output, with no wrap to zero.
- R3: The output is always a thermometer code: no zero bit lies below a one bit. The number of ones in the output equals the number of ones in the input.
- R4: An all-zero input yields an all-zero output.
- R5: An input with exactly one set bit, at any position, yields an output with only bit 0 set.
- R6: With `REGISTERED`=1, the output presented after a rising clock edge is the packed form of the input sampled at that edge, one cycle of latency.
- R7: With `REGISTERED`=1, a high `rst` at a rising edge clears the output to all zeros, whatever the input is.
- R8: With `REGISTERED`=0, the output is a purely combinational function of the current input, and `clk` and `rst` have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset of the output register |
| vec_in | input | WIDTH | Vector whose ones are packed |
| vec_out | output | WIDTH | Thermometer code holding as many ones as `vec_in` |

## Verification
A wrong partial sum anywhere in the adder tree shifts the boundary of the thermometer code. It shows at the ports as a wrong number of low ones, in the same cycle in the combinational variant and one edge later in the registered one. A misplaced comparison constant breaks the contiguous shape or the count at the boundary index. An undersized count wraps the all-ones case to zero. Exhaustive sweeps of the narrow widths and many random wide vectors expose each of these faults on the first vector that crosses the faulty boundary.

// File: rtl/therm_pkg.sv
package therm_pkg;
  // Count width able to hold the value n (not just n-1).
  function automatic int count_bits(input int n);
    return $clog2(n + 1);
  endfunction
endpackage

// File: rtl/ones_tree.sv
// Balanced ones counter: split at the midpoint, add the halves.
module ones_tree #(
  parameter int N  = 4,
  parameter int CW = 3
) (
  input  logic [N-1:0]  bits,
  output logic [CW-1:0] sum
);
  localparam int MID = N / 2;

  generate
    if (N == 1) begin : g_leaf
      assign sum = {{(CW-1){1'b0}}, bits[0]};
    end else begin : g_node
      logic [CW-1:0] lo_sum;
      logic [CW-1:0] hi_sum;
      ones_tree #(.N(MID), .CW(CW)) u_lo (
        .bits (bits[MID-1:0]),
        .sum  (lo_sum)
      );
      ones_tree #(.N(N-MID), .CW(CW)) u_hi (
        .bits (bits[N-1:MID]),
        .sum  (hi_sum)
      );
      assign sum = lo_sum + hi_sum;
    end
  endgenerate
endmodule

// File: rtl/therm_cmp.sv
// Converts a count into a thermometer code, one comparator per bit.
module therm_cmp #(
  parameter int N  = 4,
  parameter int CW = 3
) (
  input  logic [CW-1:0] count,
  output logic [N-1:0]  therm
);
  generate
    for (genvar i = 0; i < N; i++) begin : g_bit
      localparam logic [CW-1:0] IDX = CW'(i);
      assign therm[i] = (count > IDX);
    end
  endgenerate
endmodule

// File: rtl/out_stage.sv
// Optional output register with synchronous reset.
module out_stage #(
  parameter int N          = 4,
  parameter bit REGISTERED = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  generate
    if (REGISTERED) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
      end
    end else begin : g_wire
      assign q = d;
    end
  endgenerate
endmodule

// File: rtl/therm_packer.sv
module therm_packer #(
  parameter int WIDTH      = 64,
  parameter int MAX_WIDTH  = 64,
  parameter bit REGISTERED = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] vec_in,
  output logic [WIDTH-1:0] vec_out
);
  import therm_pkg::*;

  localparam int CW = count_bits(WIDTH);

  generate
    if (WIDTH < 4 || WIDTH > MAX_WIDTH) begin : g_bad_width
      $error("therm_packer: WIDTH out of range");
    end
  endgenerate

  logic [CW-1:0]    ones;
  logic [WIDTH-1:0] therm;

  ones_tree #(.N(WIDTH), .CW(CW)) u_tree (
    .bits (vec_in),
    .sum  (ones)
  );

  therm_cmp #(.N(WIDTH), .CW(CW)) u_cmp (
    .count (ones),
    .therm (therm)
  );

  out_stage #(.N(WIDTH), .REGISTERED(REGISTERED)) u_out (
    .clk (clk),
    .rst (rst),
    .d   (therm),
    .q   (vec_out)
  );

  AST_COUNT_MATCH: assert property (@(posedge clk) disable iff (rst)
    32'(ones) == $countones(vec_in)) else $error("count mismatch"); // R2
  AST_THERM_SHAPE: assert property (@(posedge clk) disable iff (rst)
    (vec_out & (vec_out + 1'b1)) == '0) else $error("not thermometer"); // R3
  AST_THERM_ONES: assert property (@(posedge clk) disable iff (rst)
    $countones(therm) == $countones(vec_in)) else $error("ones lost"); // R3
  AST_ZERO_IN: assert property (@(posedge clk) disable iff (rst)
    (vec_in == '0) |-> (therm == '0)) else $error("zero not kept"); // R4

  generate
    if (REGISTERED) begin : g_reg_chk
      AST_REG_LATENCY: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (vec_out == $past(therm))) else $error("latency"); // R6
      AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (vec_out == '0)) else $error("reset"); // R7
    end else begin : g_comb_chk
      AST_COMB_PASS: assert property (@(posedge clk) disable iff (rst)
        vec_out == therm) else $error("comb path"); // R8
    end
  endgenerate
endmodule

// File: tb/therm_packer_test.sv
`timescale 1ns/1ps
module therm_packer_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [3:0]  in4  = '0;
  logic [3:0]  out4;
  logic [7:0]  in8  = '0;
  logic [7:0]  out8;
  logic [63:0] in64 = '0;
  logic [63:0] out64;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  therm_packer #(.WIDTH(4), .MAX_WIDTH(64), .REGISTERED(1'b0)) uut4 (
    .clk(clk), .rst(rst), .vec_in(in4), .vec_out(out4));
  therm_packer #(.WIDTH(8), .MAX_WIDTH(64), .REGISTERED(1'b1)) uut8 (
    .clk(clk), .rst(rst), .vec_in(in8), .vec_out(out8));
  therm_packer #(.WIDTH(64), .MAX_WIDTH(64), .REGISTERED(1'b1)) uut (
    .clk(clk), .rst(rst), .vec_in(in64), .vec_out(out64));

  // Reference: count ones, then set the low `count` bits.
  function automatic logic [63:0] pack_ref(input logic [63:0] v, input int n);
    int c = 0;
    logic [63:0] r = '0;
    for (int i = 0; i < n; i++) c += int'(v[i]);
    for (int i = 0; i < n; i++) r[i] = (c > i);
    return r;
  endfunction

  task automatic check(input bit ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_vec(input string req, input logic [63:0] act,
                           input logic [63:0] exp);
    check(act == exp, req, act, exp);
  endtask

  initial begin
    #(5.0 * 199000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [63:0] prev;
    // R7: reset clears registered outputs despite all-ones input
    in8 = '1; in64 = '1;
    repeat (3) @(negedge clk);
    check_vec("R7 reset n8", 64'(out8), 64'h0);
    check_vec("R7 reset n64", out64, 64'h0);
    // R8: comb variant ignores reset and follows the input now
    in4 = 4'b1010; #0.5;
    check_vec("R8 comb in reset", 64'(out4), 64'h3);
    rst = 1'b0;

    // R1 R4 R5 R2 R8: exhaustive N=4, combinational
    for (int v = 0; v < 16; v++) begin
      in4 = 4'(v); #0.5;
      check_vec("R1 R8 n4 exhaustive", 64'(out4), pack_ref(64'(v), 4));
    end
    in4 = 4'b0000; #0.5; check_vec("R4 n4 zero", 64'(out4), 64'h0);
    in4 = 4'b1111; #0.5; check_vec("R2 n4 full", 64'(out4), 64'hF);
    in4 = 4'b1000; #0.5; check_vec("R5 n4 single", 64'(out4), 64'h1);

    // R6 R1: exhaustive N=8, one cycle latency
    @(negedge clk);
    for (int v = 0; v < 256; v++) begin
      in8 = 8'(v);
      @(negedge clk);
      check_vec("R6 R1 n8 exhaustive", 64'(out8), pack_ref(64'(v), 8));
    end
    // R6: output holds the previous edge's value until the next edge
    in8 = 8'hFF; @(negedge clk);
    in8 = 8'h00; #1;
    check_vec("R6 n8 hold", 64'(out8), 64'hFF);
    @(negedge clk);
    check_vec("R4 n8 zero", 64'(out8), 64'h0);

    // Directed N=64 corners
    in64 = '0; @(negedge clk); check_vec("R4 n64 zero", out64, 64'h0);
    in64 = '1; @(negedge clk); check_vec("R2 n64 full", out64, '1);
    for (int p = 0; p < 64; p++) begin
      in64 = 64'h1 << p;
      @(negedge clk);
      check_vec("R5 n64 single", out64, 64'h1);
    end
    in64 = 64'h7FFF_FFFF_FFFF_FFFF; @(negedge clk);
    check_vec("R1 n64 63 ones", out64, 64'h7FFF_FFFF_FFFF_FFFF);
    in64 = 64'hFFFF_FFFF_FFFF_FFFE; @(negedge clk);
    check_vec("R1 n64 high 63", out64, 64'h7FFF_FFFF_FFFF_FFFF);

    // Random N=64 with density mix
    void'($urandom(32'd1234));
    for (int k = 0; k < 10000; k++) begin
      logic [63:0] r;
      r = {$urandom(), $urandom()};
      case (k % 4)
        1: r = r & {$urandom(), $urandom()};
        2: r = r | {$urandom(), $urandom()};
        default: ;
      endcase
      in64 = r;
      @(negedge clk);
      prev = pack_ref(r, 64);
      check_vec("R1 R3 n64 random", out64, prev);
      check(((out64 & (out64 + 64'h1)) == 64'h0) &&
            ($countones(out64) == $countones(r)), "R3 n64 shape", out64, prev);
    end

    // R7: mid-run reset clears output
    in64 = '1; rst = 1'b1; @(negedge clk);
    check_vec("R7 n64 midrun", out64, 64'h0);
    rst = 1'b0; @(negedge clk);
    check_vec("R6 n64 after reset", out64, '1);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule